// File: doc/BRIEF.md
# Carry-Select Binary Adder

A combinational adder for two N-bit operands and a carry-in. It returns an N-bit sum, the carry-out, and a signed-overflow flag. The operands can be read as unsigned or as two's complement values. To subtract, feed the inverted subtrahend with a carry-in of 1.

The bottom LOW_W bits form a plain ripple chain. The remaining high bits are cut into segments of SEG_W bits, and the topmost segment takes whatever width is left. Each segment holds two identical ripple chains. One chain runs with a carry-in of 0 and the other with a carry-in of 1, and both work at the same time. The real carry arriving from the segment below drives a bank of two-input multiplexers. That bank passes one chain's sum bits together with that chain's carry-out. The low segment can be made narrower than the segments above it, so that its carry is already settled when the upper chains finish.

Each ripple cell is a full adder built from two half adders with an OR gate on their carries. The parameters are checked at elaboration. A split is rejected when the low part fills the whole word or when any segment is wider than 16 bits.

Top module: `csa_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `cin_i`) modulo 2^N for every input combination.
- R2: `cout_o` equals bit N of the (N+1)-bit result of `a_i` + `b_i` + `cin_i`.
- R3: `ovf_o` is 1 exactly when `a_i[N-1]` equals `b_i[N-1]` and `sum_o[N-1]` differs from them. This is the same as the carry into bit N-1 differing from the carry out of it.
- R4: `sum_o[LOW_W-1:0]` depends only on `a_i[LOW_W-1:0]`, `b_i[LOW_W-1:0]` and `cin_i`. Changing any operand bit at or above LOW_W leaves it unchanged.
- R5: A carry produced exactly at a segment boundary reaches the next segment. The boundaries are bit LOW_W + k*SEG_W for k = 0, 1, and so on. For example, (2^p - 1) + 1 gives 2^p and a carry-out of 0 for every boundary position p.
- R6: All-ones plus all-ones with a carry-in of 1 gives all-ones with a carry-out of 1. All-ones plus zero with a carry-in of 1 gives zero with a carry-out of 1.
- R7: Zero plus zero with a carry-in of 0 gives a sum of 0, a carry-out of 0 and an overflow of 0.
- R8: With `b_i` set to the bitwise inverse of x and `cin_i` = 1, `sum_o` equals `a_i` - x modulo 2^N. In that case `cout_o` is 1 exactly when `a_i` >= x as unsigned values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| cout_o | output | 1 | Carry out of bit N-1 |
| ovf_o | output | 1 | Two's complement overflow |

## Verification
In one evaluation, a carry can ripple out of the low chain and also flip the multiplexer choice of every upper segment. Long propagate runs that sit right on a segment edge provoke this: a low field of all ones plus one, or all ones plus a carry-in. Each such case is judged against an (N+1)-bit reference sum from the bench. The overflow flag and a subtraction-style carry-out are judged on the same vectors, so a wrong selection at the top segment shows up in the sum, the carry and the sign logic together.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Longest ripple chain allowed inside any one segment.
    localparam int MAX_RIPPLE = 16;

    typedef struct packed {
        logic c;
        logic s;
    } bit_res_t;

    function automatic bit_res_t half_add(input logic x, input logic y);
        bit_res_t r;
        r.s = x ^ y;
        r.c = x & y;
        return r;
    endfunction

    // Two half adders, with the two carries merged by an OR.
    function automatic bit_res_t full_add(input logic x, input logic y, input logic ci);
        bit_res_t h1;
        bit_res_t h2;
        bit_res_t r;
        h1  = half_add(x, y);
        h2  = half_add(h1.s, ci);
        r.s = h2.s;
        r.c = h1.c | h2.c;
        return r;
    endfunction

endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    import csa_pkg::*;

    logic [W:0] chain;
    assign chain[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_cell
        bit_res_t r;
        assign r          = full_add(a_i[i], b_i[i], chain[i]);
        assign sum_o[i]   = r.s;
        assign chain[i+1] = r.c;
    end

    assign cout_o = chain[W];
endmodule

// File: rtl/csa_select_seg.sv
module csa_select_seg #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sel_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    // The two speculative copies, one per assumed carry-in.
    logic [W-1:0] s_zero;
    logic [W-1:0] s_one;
    logic         c_zero;
    logic         c_one;

    csa_ripple #(.W(W)) u_zero (
        .a_i(a_i), .b_i(b_i), .cin_i(1'b0), .sum_o(s_zero), .cout_o(c_zero)
    );
    csa_ripple #(.W(W)) u_one (
        .a_i(a_i), .b_i(b_i), .cin_i(1'b1), .sum_o(s_one), .cout_o(c_one)
    );

    // W+1 two-input multiplexers: the sum bits plus the carry.
    always_comb begin
        if (sel_i) {cout_o, sum_o} = {c_one, s_one};
        else       {cout_o, sum_o} = {c_zero, s_zero};
    end
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
    parameter int N     = 32,
    parameter int LOW_W = 4,
    parameter int SEG_W = 7
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    import csa_pkg::*;

    localparam int HI_W = N - LOW_W;
    localparam int NSEG = (HI_W + SEG_W - 1) / SEG_W;

    if (LOW_W < 1 || LOW_W >= N || LOW_W > MAX_RIPPLE ||
        SEG_W < 1 || SEG_W > MAX_RIPPLE) begin : g_bad_split
        $error("csa_adder: invalid segment split");
    end

    // seg_c[k] is the real carry entering speculative segment k.
    logic [NSEG:0] seg_c;

    csa_ripple #(.W(LOW_W)) u_low (
        .a_i   (a_i[LOW_W-1:0]),
        .b_i   (b_i[LOW_W-1:0]),
        .cin_i (cin_i),
        .sum_o (sum_o[LOW_W-1:0]),
        .cout_o(seg_c[0])
    );

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam int LO = LOW_W + k * SEG_W;
        localparam int SW = ((N - LO) < SEG_W) ? (N - LO) : SEG_W;

        csa_select_seg #(.W(SW)) u_seg (
            .a_i   (a_i[LO +: SW]),
            .b_i   (b_i[LO +: SW]),
            .sel_i (seg_c[k]),
            .sum_o (sum_o[LO +: SW]),
            .cout_o(seg_c[k+1])
        );
    end

    // The carry into the top bit is recovered from that bit's sum:
    // s = a ^ b ^ c  gives  c = s ^ a ^ b.
    logic top_cin;
    assign top_cin = sum_o[N-1] ^ a_i[N-1] ^ b_i[N-1];
    assign cout_o  = seg_c[NSEG];
    assign ovf_o   = top_cin ^ seg_c[NSEG];
endmodule

// File: rtl/csa_adder_chk.sv
module csa_adder_chk #(
    parameter int N     = 32,
    parameter int LOW_W = 4
) (
    input logic [N-1:0] a_i,
    input logic [N-1:0] b_i,
    input logic         cin_i,
    input logic [N-1:0] sum_o,
    input logic         cout_o,
    input logic         ovf_o
);
    logic [N:0]     wide;
    logic [LOW_W:0] low_wide;

    always_comb begin
        wide     = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};
        low_wide = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_i[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin_i};
        if (!$isunknown({a_i, b_i, cin_i})) begin
            // R1
            sum_value_chk: assert (sum_o == wide[N-1:0]);
            // R2
            carry_out_chk: assert (cout_o == wide[N]);
            // R3
            signed_ovf_chk: assert (ovf_o == ((a_i[N-1] == b_i[N-1]) && (sum_o[N-1] != a_i[N-1])));
            // R4
            low_segment_chk: assert (sum_o[LOW_W-1:0] == low_wide[LOW_W-1:0]);
        end
    end
endmodule

bind csa_adder csa_adder_chk #(.N(N), .LOW_W(LOW_W)) chk_i (.*);

// File: tb/csa_adder_tb_top.sv
module csa_adder_tb_top;
    localparam int N     = 32;
    localparam int LOW_W = 4;
    localparam int SEG_W = 7;
    localparam int NSEG  = (N - LOW_W + SEG_W - 1) / SEG_W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] a;
    logic [N-1:0] b;
    logic         cin;
    logic [N-1:0] sum;
    logic         cout;
    logic         ovf;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10ns clk = ~clk;

    csa_adder #(.N(N), .LOW_W(LOW_W), .SEG_W(SEG_W)) dut_i (
        .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
    );

    function automatic logic [N:0] ref_add(logic [N-1:0] x, logic [N-1:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {{N{1'b0}}, c};
    endfunction

    function automatic logic ref_ovf(logic [N-1:0] x, logic [N-1:0] y, logic [N-1:0] s);
        return (x[N-1] == y[N-1]) && (s[N-1] != x[N-1]);
    endfunction

    task automatic check(input bit ok, input string req, input logic [N:0] act, input logic [N:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y, input logic c);
        @(negedge clk);
        a = x; b = y; cin = c;
        #2ns;
    endtask

    // Drives one vector and compares all three outputs (R1, R2, R3).
    task automatic run_vec(input logic [N-1:0] x, input logic [N-1:0] y, input logic c, input string tag);
        logic [N:0] e;
        apply(x, y, c);
        e = ref_add(x, y, c);
        check(sum == e[N-1:0], {tag, " R1 sum"}, {1'b0, sum}, {1'b0, e[N-1:0]});
        check(cout == e[N], {tag, " R2 cout"}, {{N{1'b0}}, cout}, {{N{1'b0}}, e[N]});
        check(ovf == ref_ovf(x, y, e[N-1:0]), {tag, " R3 ovf"},
              {{N{1'b0}}, ovf}, {{N{1'b0}}, ref_ovf(x, y, e[N-1:0])});
    endtask

    initial begin
        #(20ns * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        a = '0; b = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        #2ns;
        // R7: idle inputs held during reset give zero outputs
        check(sum == '0 && !cout && !ovf, "R7 reset state", {cout, sum}, '0);
        rst = 1'b0;

        // R7 zero plus zero
        run_vec('0, '0, 1'b0, "R7 zero");
        check(ovf == 1'b0, "R7 no overflow", {{N{1'b0}}, ovf}, '0);

        // R6 all-ones corner cases
        run_vec('1, '1, 1'b1, "R6 ones+ones+1");
        run_vec('1, '0, 1'b1, "R6 ones+cin");
        check(sum == '0 && cout, "R6 wrap to zero", {cout, sum}, {1'b1, {N{1'b0}}});
        run_vec('1, {{(N-1){1'b0}}, 1'b1}, 1'b0, "R6 ones+1");

        // R5 carries produced exactly at each segment boundary
        for (int k = 0; k < NSEG; k++) begin
            logic [N-1:0] m;
            int p;
            p = LOW_W + k * SEG_W;
            m = (N'(1) << p) - N'(1);
            run_vec(m, N'(1), 1'b0, "R5 boundary +1");
            check(sum == (N'(1) << p) && !cout, "R5 boundary value",
                  {cout, sum}, {1'b0, N'(1) << p});
            run_vec(m, '0, 1'b1, "R5 boundary cin");
            run_vec(m | (N'(1) << p), N'(1), 1'b0, "R5 two-seg ripple");
        end

        // R8 subtraction through inverted operand
        for (int i = 0; i < 200; i++) begin
            logic [N-1:0] x;
            logic [N-1:0] y;
            x = N'({$urandom, $urandom});
            y = (i % 4 == 0) ? x : N'({$urandom, $urandom});
            apply(x, ~y, 1'b1);
            check(sum == x - y, "R8 difference", {1'b0, sum}, {1'b0, x - y});
            check(cout == (x >= y), "R8 no-borrow", {{N{1'b0}}, cout}, {{N{1'b0}}, x >= y});
        end

        // R4 low sum unaffected by upper operand bits
        for (int i = 0; i < 100; i++) begin
            logic [N-1:0] x;
            logic [N-1:0] y;
            logic [LOW_W-1:0] first;
            logic c;
            x = N'({$urandom, $urandom});
            y = N'({$urandom, $urandom});
            c = 1'(i);
            apply(x, y, c);
            first = sum[LOW_W-1:0];
            x[N-1:LOW_W] = ~x[N-1:LOW_W];
            y[N-1:LOW_W] = (N-LOW_W)'($urandom);
            apply(x, y, c);
            check(sum[LOW_W-1:0] == first, "R4 low isolation",
                  {{(N+1-LOW_W){1'b0}}, sum[LOW_W-1:0]}, {{(N+1-LOW_W){1'b0}}, first});
        end

        // R1 R2 R3 constrained random, including signed overflow edges
        for (int i = 0; i < 2000; i++) begin
            logic [N-1:0] x;
            logic [N-1:0] y;
            x = N'({$urandom, $urandom});
            y = N'({$urandom, $urandom});
            case (i % 5)
                1: y = ~x;
                2: begin x[N-1] = 1'b0; y[N-1] = 1'b0; x[N-2] = 1'b1; end
                3: begin x[N-1] = 1'b1; y[N-1] = 1'b1; end
                default: ;
            endcase
            run_vec(x, y, 1'($urandom), "random");
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule